// File: doc/BRIEF.md
# Passive LCD Scan Timing Generator

This block produces the scan timing for a passive matrix panel driven at 1/160 duty. In the primary role it divides a single oscillator clock into a column latch strobe, a frame pulse that marks the start of each half frame, two level-select lines for the row drivers, and a blanking output. In the secondary role its own divider stops. Strobe and frame timing then come in from another unit, and the block derives the same row level selects and the same blanking from those incoming edges.

One frame is two half frames of 81 strobes each, so a frame takes 2592 oscillator clocks. The two row level lines step through four phases, one per half frame. After reset the blanking output is held active for four full frames, so the panel stays dark while the scan settles. After that it simply mirrors the external blanking request.

Top module: `lcd_frame_timer`

## Requirements
- R1: In primary mode (`master_sel`=1) the strobe has a period of 16 clocks. After the N-th clock edge following reset release, with d = N mod 16, `strobe_out` is 1 exactly when 1 <= d <= 8.
- R2: Each half frame holds 81 strobes, numbered 0 to 80. The strobe index after N edges is floor(N/16) mod 81, so a half frame lasts 1296 clocks and a frame lasts 2592.
- R3: `frame_out` is 1 exactly while `strobe_out` is 1 during strobe 0 of a half frame. It therefore pulses twice per frame.
- R4: A row phase counter (0..3) advances by one at every frame event and equals 3 during reset. `lvl_sel_a` is 1 in phases 0 and 1 and 0 in phases 2 and 3. It changes only on a frame event.
- R5: `lvl_sel_b` starts each half frame at 1 in phase 0, 0 in phase 1, 0 in phase 2 and 1 in phase 3. It inverts at every later strobe of that half frame.
- R6: While `rst_n` is 0 the outputs are `strobe_out`=0, `frame_out`=0, `lvl_sel_a`=0, `lvl_sel_b`=1 and `blank_out`=1, and all counters are cleared.
- R7: After reset, `blank_out` stays 1 until nine frame events have been taken, whatever `disp_off_req` is. In primary mode that is 10368 clocks, which is four frames.
- R8: Once the blanking period has ended, `blank_out` equals `disp_off_req` combinationally.
- R9: In secondary mode (`master_sel`=0) the divider is idle and `strobe_out` and `frame_out` stay 0. Each rising edge of `strobe_in`, seen through a two-stage synchronizer, is a strobe event. It is also a frame event if `frame_in` is 1 at that edge.
- R10: In secondary mode the R4, R5 and R7 behaviour runs from the incoming strobe and frame events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 = generate timing, 0 = follow incoming timing |
| disp_off_req | input | 1 | External blanking request, active high |
| strobe_in | input | 1 | Incoming column strobe (secondary mode) |
| frame_in | input | 1 | Incoming frame pulse, active high (secondary mode) |
| strobe_out | output | 1 | Generated column latch strobe |
| frame_out | output | 1 | Generated frame pulse, active high |
| lvl_sel_a | output | 1 | Row level select, constant within a phase |
| lvl_sel_b | output | 1 | Row level select, toggles per strobe |
| blank_out | output | 1 | Display-off output, active high |

## Verification
The hardest state to reach is the end of the power-up blanking. In primary mode it arrives only after 10368 clocks, and at that point all four row phases have already been crossed twice. The bench therefore runs one uninterrupted primary-mode stretch of 11500 cycles from reset and compares every output in every cycle against a model built from the edge count. It pulses the blanking request once, after blanking has ended. In secondary mode the nine frame events are supplied by hand-driven strobes, so the release can be checked edge by edge.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  typedef enum logic [1:0] {
    PH_A1_B1 = 2'd0,
    PH_A1_B0 = 2'd1,
    PH_A0_B0 = 2'd2,
    PH_A0_B1 = 2'd3
  } row_phase_e;

  // value of the toggling row select on the first strobe of a half frame
  function automatic logic phase_b_start(input row_phase_e ph);
    return (ph == PH_A1_B1) || (ph == PH_A0_B1);
  endfunction

  // constant row select for the phase
  function automatic logic phase_a_level(input row_phase_e ph);
    return (ph == PH_A1_B1) || (ph == PH_A1_B0);
  endfunction

endpackage

// File: rtl/lcd_tg_divider.sv
module lcd_tg_divider #(
  parameter int DIV_LEN      = 16,
  parameter int STB_PER_HALF = 81
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic stb_o,
  output logic frm_o,
  output logic ev_stb,
  output logic ev_frm
);
  localparam int DW      = $clog2(DIV_LEN);
  localparam int SW      = $clog2(STB_PER_HALF);
  localparam int HALF_HI = DIV_LEN / 2;

  logic [DW-1:0] div_q, div_d;
  logic [SW-1:0] sidx_q, sidx_d;
  logic          div_wrap;

  assign div_wrap = (div_q == DW'(DIV_LEN - 1));

  always_comb begin
    div_d  = div_q;
    sidx_d = sidx_q;
    if (!run) begin
      div_d  = '0;
      sidx_d = '0;
    end else begin
      div_d = div_wrap ? '0 : div_q + 1'b1;
      if (div_wrap) begin
        sidx_d = (sidx_q == SW'(STB_PER_HALF - 1)) ? '0 : sidx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sidx_q <= '0;
    end else begin
      div_q  <= div_d;
      sidx_q <= sidx_d;
    end
  end

  assign stb_o  = run && (div_q >= DW'(1)) && (div_q <= DW'(HALF_HI));
  assign frm_o  = stb_o && (sidx_q == '0);
  assign ev_stb = run && (div_q == '0);
  assign ev_frm = ev_stb && (sidx_q == '0);

  // R2
  sidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sidx_q <= SW'(STB_PER_HALF - 1));

  // R1
  stb_after_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stb && run |=> stb_o || !run);

endmodule

// File: rtl/lcd_tg_follower.sv
module lcd_tg_follower #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_in,
  input  logic frm_in,
  output logic ev_stb,
  output logic ev_frm
);
  logic [SYNC_STAGES-1:0] stb_q, frm_q;
  logic                   stb_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      frm_q <= '0;
    end else begin
      stb_q[0] <= stb_in;
      frm_q[0] <= frm_in;
    end
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stb_q[i] <= 1'b0;
        frm_q[i] <= 1'b0;
      end else begin
        stb_q[i] <= stb_q[i-1];
        frm_q[i] <= frm_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_last_q <= 1'b0;
    else        stb_last_q <= stb_q[SYNC_STAGES-1];
  end

  assign ev_stb = stb_q[SYNC_STAGES-1] && !stb_last_q;
  assign ev_frm = ev_stb && frm_q[SYNC_STAGES-1];

endmodule

// File: rtl/lcd_tg_rowphase.sv
module lcd_tg_rowphase
  import lcd_tg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_stb,
  input  logic ev_frm,
  output logic lvl_a,
  output logic lvl_b
);
  row_phase_e ph_q, ph_d;
  logic       tog_q, tog_d;

  always_comb begin
    ph_d  = ph_q;
    tog_d = tog_q;
    if (ev_stb) begin
      if (ev_frm) begin
        ph_d  = row_phase_e'(ph_q + 2'd1);
        tog_d = 1'b0;
      end else begin
        tog_d = !tog_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_A0_B1;
      tog_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      tog_q <= tog_d;
    end
  end

  assign lvl_a = phase_a_level(ph_q);
  assign lvl_b = phase_b_start(ph_q) ^ tog_q;

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frm |=> ph_q == row_phase_e'($past(ph_q) + 2'd1));

  // R5
  b_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stb && !ev_frm) |=> lvl_b != $past(lvl_b));

endmodule

// File: rtl/lcd_tg_blank.sv
module lcd_tg_blank #(
  parameter int BLANK_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_frm,
  input  logic req,
  output logic blank_o
);
  localparam int LIMIT = 2 * BLANK_FRAMES + 1;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          holding;

  assign holding = (cnt_q < CW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (ev_frm && holding) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign blank_o = holding || req;

  // R7
  blank_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_o) |-> ($past(ev_frm) || $past(req)));

  // R8
  req_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> blank_o);

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int DIV_LEN      = 16,
  parameter int STB_PER_HALF = 81,
  parameter int BLANK_FRAMES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_osc,
  input  logic rst_n,
  input  logic master_sel,
  input  logic disp_off_req,
  input  logic strobe_in,
  input  logic frame_in,
  output logic strobe_out,
  output logic frame_out,
  output logic lvl_sel_a,
  output logic lvl_sel_b,
  output logic blank_out
);
  logic gen_ev_stb, gen_ev_frm;
  logic fol_ev_stb, fol_ev_frm;
  logic ev_stb, ev_frm;

  lcd_tg_divider #(
    .DIV_LEN      (DIV_LEN),
    .STB_PER_HALF (STB_PER_HALF)
  ) u_div (
    .clk    (clk_osc),
    .rst_n  (rst_n),
    .run    (master_sel),
    .stb_o  (strobe_out),
    .frm_o  (frame_out),
    .ev_stb (gen_ev_stb),
    .ev_frm (gen_ev_frm)
  );

  lcd_tg_follower #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_fol (
    .clk    (clk_osc),
    .rst_n  (rst_n),
    .stb_in (strobe_in),
    .frm_in (frame_in),
    .ev_stb (fol_ev_stb),
    .ev_frm (fol_ev_frm)
  );

  always_comb begin
    if (master_sel) begin
      ev_stb = gen_ev_stb;
      ev_frm = gen_ev_frm;
    end else begin
      ev_stb = fol_ev_stb;
      ev_frm = fol_ev_frm;
    end
  end

  lcd_tg_rowphase u_row (
    .clk    (clk_osc),
    .rst_n  (rst_n),
    .ev_stb (ev_stb),
    .ev_frm (ev_frm),
    .lvl_a  (lvl_sel_a),
    .lvl_b  (lvl_sel_b)
  );

  lcd_tg_blank #(
    .BLANK_FRAMES (BLANK_FRAMES)
  ) u_blank (
    .clk     (clk_osc),
    .rst_n   (rst_n),
    .ev_frm  (ev_frm),
    .req     (disp_off_req),
    .blank_o (blank_out)
  );

  // R3
  frame_in_strobe_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    frame_out |-> strobe_out);

  // R4
  a_moves_on_frame_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !$stable(lvl_sel_a) |-> $past(ev_frm));

  // R9
  follower_quiet_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !master_sel && $stable(master_sel) |-> !strobe_out && !frame_out);

endmodule

// File: tb/sim_lcd_frame_timer.sv
module sim_lcd_frame_timer;

  typedef struct packed {
    logic stb;
    logic frm;
    logic la;
    logic lb;
    logic blk;
  } vec_t;

  logic clk = 1'b0;
  logic rst_n;
  logic master_sel, disp_off_req, strobe_in, frame_in;
  logic strobe_out, frame_out, lvl_sel_a, lvl_sel_b, blank_out;

  int checks = 0;
  int fails  = 0;
  vec_t sb_q[$];

  always #10 clk = !clk;  // 50 MHz

  lcd_frame_timer u0 (
    .clk_osc      (clk),
    .rst_n        (rst_n),
    .master_sel   (master_sel),
    .disp_off_req (disp_off_req),
    .strobe_in    (strobe_in),
    .frame_in     (frame_in),
    .strobe_out   (strobe_out),
    .frame_out    (frame_out),
    .lvl_sel_a    (lvl_sel_a),
    .lvl_sel_b    (lvl_sel_b),
    .blank_out    (blank_out)
  );

  // expected outputs after m edges in primary mode (R1..R8)
  function automatic vec_t model(input int m, input logic req);
    vec_t v;
    int d, sidx, s, f, ph, j;
    d    = m % 16;
    sidx = (m / 16) % 81;
    s    = (m + 15) / 16;
    f    = (m + 1295) / 1296;
    ph   = (3 + f) % 4;
    j    = (s - 1) % 81;
    v.stb = (d >= 1) && (d <= 8);
    v.frm = v.stb && (sidx == 0);
    v.la  = (ph < 2);
    v.lb  = ((ph == 0) || (ph == 3)) ^ logic'(j % 2);
    v.blk = (f < 9) || req;
    return v;
  endfunction

  function automatic string tag_of(input vec_t a, input vec_t e);
    if (a.stb != e.stb) return "R1";
    if (a.frm != e.frm) return "R3";
    if (a.la  != e.la)  return "R4";
    if (a.lb  != e.lb)  return "R5";
    if (e.blk && !a.blk) return "R7";
    return "R8";
  endfunction

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops expected vectors one per cycle after the active edge
  logic mon_en = 1'b0;
  always @(posedge clk) begin
    #5;
    if (mon_en && sb_q.size() > 0) begin
      vec_t e, a;
      e = sb_q.pop_front();
      a = '{stb: strobe_out, frm: frame_out, la: lvl_sel_a, lb: lvl_sel_b, blk: blank_out};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s actual=%b expected=%b at %0t", tag_of(a, e), a, e, $time);
      end
    end
  end

  // driver: primary-mode run, pushes the expectation for each coming edge
  task automatic drive_primary(input int ncyc);
    for (int k = 0; k < ncyc; k++) begin
      logic rq;
      rq = (k >= 11000) && (k < 11200);  // R8 request pulse after blanking
      disp_off_req = rq;
      sb_q.push_back(model(k + 1, rq));
      @(negedge clk);
    end
  endtask

  // secondary-mode strobe, then settle
  task automatic slave_strobe(input logic with_frame);
    strobe_in = 1'b1;
    frame_in  = with_frame;
    repeat (6) @(negedge clk);
    strobe_in = 1'b0;
    frame_in  = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    master_sel   = 1'b1;
    disp_off_req = 1'b0;
    strobe_in    = 1'b0;
    frame_in     = 1'b0;
    repeat (3) @(negedge clk);
    // R6 reset state in primary mode
    check1("R6 strobe", strobe_out, 1'b0);
    check1("R6 frame",  frame_out,  1'b0);
    check1("R6 lvl_a",  lvl_sel_a,  1'b0);
    check1("R6 lvl_b",  lvl_sel_b,  1'b1);
    check1("R6 blank",  blank_out,  1'b1);

    // R1 R2 R3 R4 R5 R7 R8 primary scoreboard run across blanking release
    rst_n  = 1'b1;
    mon_en = 1'b1;
    drive_primary(11500);
    @(posedge clk);
    #8;
    mon_en = 1'b0;
    sb_q.delete();

    // R9 R10 secondary mode from a fresh reset
    @(negedge clk);
    rst_n      = 1'b0;
    master_sel = 1'b0;
    disp_off_req = 1'b0;
    repeat (2) @(negedge clk);
    check1("R6 slave lvl_a", lvl_sel_a, 1'b0);
    check1("R6 slave lvl_b", lvl_sel_b, 1'b1);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check1("R9 idle strobe", strobe_out, 1'b0);
    check1("R9 idle frame",  frame_out,  1'b0);
    check1("R10 no event lvl_a", lvl_sel_a, 1'b0);

    slave_strobe(1'b1);  // frame event 1 -> phase 0
    check1("R10 ph0 lvl_a", lvl_sel_a, 1'b1);
    check1("R10 ph0 lvl_b", lvl_sel_b, 1'b1);
    check1("R9 strobe_out quiet", strobe_out, 1'b0);
    slave_strobe(1'b0);
    check1("R5 slave toggle", lvl_sel_b, 1'b0);
    slave_strobe(1'b0);
    check1("R5 slave toggle back", lvl_sel_b, 1'b1);
    slave_strobe(1'b1);  // 2 -> phase 1
    check1("R10 ph1 lvl_a", lvl_sel_a, 1'b1);
    check1("R10 ph1 lvl_b", lvl_sel_b, 1'b0);
    slave_strobe(1'b1);  // 3 -> phase 2
    check1("R10 ph2 lvl_a", lvl_sel_a, 1'b0);
    check1("R10 ph2 lvl_b", lvl_sel_b, 1'b0);
    slave_strobe(1'b1);  // 4 -> phase 3
    check1("R10 ph3 lvl_a", lvl_sel_a, 1'b0);
    check1("R10 ph3 lvl_b", lvl_sel_b, 1'b1);
    slave_strobe(1'b0);
    check1("R5 ph3 toggle", lvl_sel_b, 1'b0);
    for (int i = 5; i <= 8; i++) slave_strobe(1'b1);
    check1("R7 slave blank after 8", blank_out, 1'b1);
    check1("R4 wrap to ph3 lvl_a", lvl_sel_a, 1'b0);
    slave_strobe(1'b1);  // ninth frame event ends blanking
    check1("R7 slave blank released", blank_out, 1'b0);
    check1("R4 wrap ph0 lvl_a", lvl_sel_a, 1'b1);
    disp_off_req = 1'b1;
    @(negedge clk);
    check1("R8 request on", blank_out, 1'b1);
    disp_off_req = 1'b0;
    @(negedge clk);
    check1("R8 request off", blank_out, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule